// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This block holds the 16-bit stack pointer of a small 8-bit processor. The pipeline raises one of four command strobes: push a data byte, pop a data byte, enter a subroutine or interrupt (two-byte return address push), or return (two-byte pop). For each command the unit presents the memory address or addresses the stack access must use, and on the next clock edge it moves the pointer by the right step. The stack grows toward lower addresses. Data bytes move the pointer by one and return addresses move it by two.

Software sees the pointer as two 8-bit read/write I/O registers, a low byte and a high byte. A software write always wins over a stack command in the same cycle. A build parameter removes the high byte for small data spaces. The unit also raises an out-of-range flag whenever an access would touch an address at or below the protected floor, or above the top of data memory.

Top module: `stackPointerUnit`

## Requirements
- R1: After reset the pointer reads back as TOP_ADDR (default 0x08FF), masked to 8 bits when the high byte is absent.
- R2: A lone push strobe gives accValid=1, accWide=0 and accAddr0 equal to the current pointer. The pointer then decreases by 1.
- R3: A lone pop strobe gives accValid=1, accWide=0 and accAddr0 equal to the pointer plus 1. The pointer then increases by 1.
- R4: A lone call strobe gives accWide=1, accAddr0 equal to the pointer and accAddr1 equal to the pointer minus 1. The pointer then decreases by 2.
- R5: A lone return strobe gives accWide=1, accAddr0 equal to the pointer plus 1 and accAddr1 equal to the pointer plus 2. The pointer then increases by 2.
- R6: ioRdHi shows pointer bits 15:8 and ioRdLo shows bits 7:0. ioWrLo loads ioWrData into bits 7:0 and ioWrHi loads it into bits 15:8. Each write takes effect at the next edge and leaves the other byte unchanged.
- R7: When ioWrLo or ioWrHi is high in the same cycle as a command strobe, the pointer changes only by the software write. The command's step is dropped.
- R8: rangeErr is 1 exactly when accValid is 1 and some address of the access (accAddr0, plus accAddr1 when accWide) is at or below FLOOR_ADDR (default 0x0100) or above TOP_ADDR.
- R9: With HAS_HIGH=0, ioRdHi always reads 0, high-byte writes are ignored, and pointer steps wrap within 8 bits.
- R10: When more than one command strobe is high, accValid is 0 and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdPush | input | 1 | Push one data byte |
| cmdPop | input | 1 | Pop one data byte |
| cmdCall | input | 1 | Push a two-byte return address |
| cmdRet | input | 1 | Pop a two-byte return address |
| ioWrLo | input | 1 | Software write to pointer low byte |
| ioWrHi | input | 1 | Software write to pointer high byte |
| ioWrData | input | 8 | Software write data |
| ioRdLo | output | 8 | Pointer bits 7:0 |
| ioRdHi | output | 8 | Pointer bits 15:8 (zero when absent) |
| accValid | output | 1 | A single valid command requests a stack access |
| accWide | output | 1 | The access covers two bytes |
| accAddr0 | output | 16 | First access address |
| accAddr1 | output | 16 | Second access address (wide accesses) |
| rangeErr | output | 1 | Access touches an address outside the stack region |

## Verification
The bench targets the pre-increment versus post-decrement asymmetry. A design that swapped it would read a pop from the slot it had just left, or write a push one slot low. Wide returns at the top and calls just above the floor check that the second address is range-checked too. A design that checks only accAddr0 misses the error there. Software writes that collide with commands catch a design that applies both updates. Multi-strobe cycles catch a design that walks the pointer on malformed commands. An 8-bit instance is stepped across zero to show wrapping and the dead high byte.

// File: rtl/stackPtrPkg.sv
package stackPtrPkg;
  typedef struct packed {
    logic access;   // exactly one command strobe
    logic update;   // apply the command step this edge
    logic down;     // toward lower addresses
    logic wide;     // two-byte access
    logic wrLo;
    logic wrHi;
  } spStrobes_t;
endpackage

// File: rtl/spControl.sv
module spControl
  import stackPtrPkg::*;
(
  input  logic       cmdPush,
  input  logic       cmdPop,
  input  logic       cmdCall,
  input  logic       cmdRet,
  input  logic       ioWrLo,
  input  logic       ioWrHi,
  output spStrobes_t strb
);
  logic [3:0] cmdVec;
  logic       single;
  logic       swWrite;

  assign cmdVec  = {cmdRet, cmdCall, cmdPop, cmdPush};
  assign single  = (cmdVec != 4'b0) && ((cmdVec & (cmdVec - 4'd1)) == 4'b0);
  assign swWrite = ioWrLo | ioWrHi;

  always_comb begin
    strb        = '0;
    strb.access = single;
    strb.update = single & ~swWrite;
    strb.down   = cmdPush | cmdCall;
    strb.wide   = cmdCall | cmdRet;
    strb.wrLo   = ioWrLo;
    strb.wrHi   = ioWrHi;
  end
endmodule

// File: rtl/spDatapath.sv
module spDatapath
  import stackPtrPkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] TOP_ADDR   = 16'h08FF,
  parameter logic [15:0] FLOOR_ADDR = 16'h0100,
  parameter bit          HAS_HIGH   = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  spStrobes_t        strb,
  input  logic [7:0]        wrData,
  output logic [ADDR_W-1:0] spVal,
  output logic [ADDR_W-1:0] addr0,
  output logic [ADDR_W-1:0] addr1,
  output logic              accValid,
  output logic              accWide,
  output logic              rangeErr
);
  localparam int              USED_W   = HAS_HIGH ? ADDR_W : 8;
  localparam logic [ADDR_W-1:0] SP_MASK = (ADDR_W)'((1 << USED_W) - 1);
  localparam logic [ADDR_W-1:0] RST_VAL = TOP_ADDR & SP_MASK;

  logic [ADDR_W-1:0] spQ, spNext, stepAmt, stepped, loaded;
  logic [7:0]        hiNext;
  logic              bad0, bad1;

  generate
    if (HAS_HIGH) begin : g_hiByte
      assign hiNext = strb.wrHi ? wrData : spQ[15:8];
    end else begin : g_noHiByte
      assign hiNext = 8'h00;
    end
  endgenerate

  assign loaded  = {hiNext, (strb.wrLo ? wrData : spQ[7:0])};
  assign stepAmt = strb.wide ? (ADDR_W)'(2) : (ADDR_W)'(1);
  assign stepped = (strb.down ? (spQ - stepAmt) : (spQ + stepAmt)) & SP_MASK;

  always_comb begin
    spNext = spQ;
    if (strb.wrLo || strb.wrHi) spNext = loaded & SP_MASK;
    else if (strb.update)       spNext = stepped;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) spQ <= RST_VAL;
    else       spQ <= spNext;
  end

  // push/call write at SP then SP-1; pop/ret read at SP+1 then SP+2
  assign addr0 = (strb.down ? spQ : (spQ + (ADDR_W)'(1))) & SP_MASK;
  assign addr1 = (strb.down ? (spQ - (ADDR_W)'(1)) : (spQ + (ADDR_W)'(2))) & SP_MASK;

  assign bad0     = (addr0 <= FLOOR_ADDR) || (addr0 > TOP_ADDR);
  assign bad1     = (addr1 <= FLOOR_ADDR) || (addr1 > TOP_ADDR);
  assign accValid = strb.access;
  assign accWide  = strb.access & strb.wide;
  assign rangeErr = strb.access & (bad0 | (strb.wide & bad1));
  assign spVal    = spQ;
endmodule

// File: rtl/stackPointerUnit.sv
module stackPointerUnit
  import stackPtrPkg::*;
#(
  parameter logic [15:0] TOP_ADDR   = 16'h08FF,
  parameter logic [15:0] FLOOR_ADDR = 16'h0100,
  parameter bit          HAS_HIGH   = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdPush,
  input  logic        cmdPop,
  input  logic        cmdCall,
  input  logic        cmdRet,
  input  logic        ioWrLo,
  input  logic        ioWrHi,
  input  logic [7:0]  ioWrData,
  output logic [7:0]  ioRdLo,
  output logic [7:0]  ioRdHi,
  output logic        accValid,
  output logic        accWide,
  output logic [15:0] accAddr0,
  output logic [15:0] accAddr1,
  output logic        rangeErr
);
  spStrobes_t  strb;
  logic [15:0] spVal;

  spControl ctrl_i (
    .cmdPush(cmdPush), .cmdPop(cmdPop), .cmdCall(cmdCall), .cmdRet(cmdRet),
    .ioWrLo(ioWrLo), .ioWrHi(ioWrHi), .strb(strb)
  );

  spDatapath #(
    .ADDR_W(16), .TOP_ADDR(TOP_ADDR), .FLOOR_ADDR(FLOOR_ADDR), .HAS_HIGH(HAS_HIGH)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(ioWrData), .spVal(spVal),
    .addr0(accAddr0), .addr1(accAddr1), .accValid(accValid), .accWide(accWide),
    .rangeErr(rangeErr)
  );

  assign ioRdLo = spVal[7:0];
  assign ioRdHi = spVal[15:8];
endmodule

// File: rtl/spChecker.sv
module spChecker #(
  parameter logic [15:0] TOP_ADDR   = 16'h08FF,
  parameter logic [15:0] FLOOR_ADDR = 16'h0100,
  parameter bit          HAS_HIGH   = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic        cmdPush,
  input logic        cmdPop,
  input logic        cmdCall,
  input logic        cmdRet,
  input logic        ioWrLo,
  input logic        ioWrHi,
  input logic [7:0]  ioWrData,
  input logic [7:0]  ioRdLo,
  input logic [7:0]  ioRdHi,
  input logic        accValid,
  input logic [15:0] accAddr0,
  input logic        rangeErr
);
  localparam logic [15:0] MASK = HAS_HIGH ? 16'hFFFF : 16'h00FF;
  logic [15:0] sp;
  logic        noWr;
  assign sp   = {ioRdHi, ioRdLo};
  assign noWr = !ioWrLo && !ioWrHi;

  a_r1_reset_top: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> sp == (TOP_ADDR & MASK));

  a_r2_push_step: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPush && !cmdPop && !cmdCall && !cmdRet && noWr)
      |=> sp == (($past(sp) - 16'd1) & MASK));

  a_r4_call_step: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCall && !cmdPush && !cmdPop && !cmdRet && noWr)
      |=> sp == (($past(sp) - 16'd2) & MASK));

  a_r5_ret_step: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRet && !cmdPush && !cmdPop && !cmdCall && noWr)
      |=> sp == (($past(sp) + 16'd2) & MASK));

  a_r7_sw_wins: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrLo && !ioWrHi) |=> (ioRdLo == $past(ioWrData)) && (ioRdHi == $past(ioRdHi)));

  a_r8_floor_flag: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && (accAddr0 <= FLOOR_ADDR || accAddr0 > TOP_ADDR)) |-> rangeErr);

  a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> !rangeErr);

  a_r10_multi_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($countones({cmdPush, cmdPop, cmdCall, cmdRet}) > 1 && noWr)
      |-> (!accValid ##1 $stable(sp)));
endmodule

bind stackPointerUnit spChecker #(
  .TOP_ADDR(TOP_ADDR), .FLOOR_ADDR(FLOOR_ADDR), .HAS_HIGH(HAS_HIGH)
) chk_i (
  .clk(clk), .rstN(rstN), .cmdPush(cmdPush), .cmdPop(cmdPop), .cmdCall(cmdCall),
  .cmdRet(cmdRet), .ioWrLo(ioWrLo), .ioWrHi(ioWrHi), .ioWrData(ioWrData),
  .ioRdLo(ioRdLo), .ioRdHi(ioRdHi), .accValid(accValid), .accAddr0(accAddr0),
  .rangeErr(rangeErr)
);

// File: tb/stackPointerUnit_tb_top.sv
module stackPointerUnit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] TOP   = 16'h08FF;
  localparam logic [15:0] FLOOR = 16'h0100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdPush = 0, cmdPop = 0, cmdCall = 0, cmdRet = 0, ioWrLo = 0, ioWrHi = 0;
  logic [7:0] ioWrData = 8'h00;
  logic [7:0] ioRdLo, ioRdHi, sRdLo, sRdHi;
  logic accValid, accWide, rangeErr, sValid, sWide, sErr;
  logic [15:0] accAddr0, accAddr1, sAddr0, sAddr1;
  logic sPush = 0, sCall = 0, sWrLo = 0, sWrHi = 0;
  logic [7:0] sData = 8'h00;

  int checks = 0;
  int fails  = 0;
  int spM;

  always #(CLK_PERIOD/2) clk = ~clk;

  stackPointerUnit dut_i (
    .clk(clk), .rstN(rstN), .cmdPush(cmdPush), .cmdPop(cmdPop), .cmdCall(cmdCall),
    .cmdRet(cmdRet), .ioWrLo(ioWrLo), .ioWrHi(ioWrHi), .ioWrData(ioWrData),
    .ioRdLo(ioRdLo), .ioRdHi(ioRdHi), .accValid(accValid), .accWide(accWide),
    .accAddr0(accAddr0), .accAddr1(accAddr1), .rangeErr(rangeErr)
  );

  stackPointerUnit #(.TOP_ADDR(16'h00F0), .FLOOR_ADDR(16'h0040), .HAS_HIGH(1'b0)) dutSmall_i (
    .clk(clk), .rstN(rstN), .cmdPush(sPush), .cmdPop(1'b0), .cmdCall(sCall),
    .cmdRet(1'b0), .ioWrLo(sWrLo), .ioWrHi(sWrHi), .ioWrData(sData),
    .ioRdLo(sRdLo), .ioRdHi(sRdHi), .accValid(sValid), .accWide(sWide),
    .accAddr0(sAddr0), .accAddr1(sAddr1), .rangeErr(sErr)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit outside(input int a);
    return (a <= FLOOR) || (a > TOP);
  endfunction

  // one clock of the reference model; called just after a falling edge
  task automatic cycle(input bit pu, input bit po, input bit ca, input bit re,
                       input bit wl, input bit wh, input logic [7:0] d);
    int n, a0, a1, nxt;
    bit down, wide, valid;
    string tag;
    cmdPush = pu; cmdPop = po; cmdCall = ca; cmdRet = re;
    ioWrLo = wl; ioWrHi = wh; ioWrData = d;
    n = pu + po + ca + re;
    valid = (n == 1);
    down = pu | ca;
    wide = ca | re;
    a0 = down ? spM : (spM + 1) & 16'hFFFF;
    a1 = down ? (spM - 1) & 16'hFFFF : (spM + 2) & 16'hFFFF;
    if (n > 1)          tag = "R10";
    else if (wl || wh)  tag = (n == 1) ? "R7" : "R6";
    else if (pu)        tag = "R2";
    else if (po)        tag = "R3";
    else if (ca)        tag = "R4";
    else if (re)        tag = "R5";
    else                tag = "R6";
    #1;
    check(tag, accValid, valid);
    if (valid) begin
      check(tag, accWide, wide);
      check(tag, accAddr0, a0);
      if (wide) check(tag, accAddr1, a1);
      check("R8", rangeErr, outside(a0) || (wide && outside(a1)));
    end else begin
      check("R8", rangeErr, 0);
    end
    nxt = spM;
    if (wl || wh) begin
      if (wl) nxt = (nxt & 16'hFF00) | d;
      if (wh) nxt = (nxt & 16'h00FF) | (int'(d) << 8);
    end else if (valid) begin
      nxt = down ? spM - (wide ? 2 : 1) : spM + (wide ? 2 : 1);
      nxt = nxt & 16'hFFFF;
    end
    @(posedge clk);
    spM = nxt;
    @(negedge clk);
    check(tag, {ioRdHi, ioRdLo}, spM);
  endtask

  task automatic setSp(input int v);
    cycle(0, 0, 0, 0, 1, 1, 8'(v >> 8));   // sets hi (and lo to same byte)
    cycle(0, 0, 0, 0, 1, 0, 8'(v));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    spM = TOP;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {ioRdHi, ioRdLo}, TOP);
    check("R1", {sRdHi, sRdLo}, 16'h00F0);
    check("R8", rangeErr, 0);

    // push then pop: access addresses differ by pre/post step
    repeat (3) cycle(1, 0, 0, 0, 0, 0, 0);
    repeat (3) cycle(0, 1, 0, 0, 0, 0, 0);
    cycle(0, 0, 1, 0, 0, 0, 0);
    cycle(0, 0, 1, 0, 0, 0, 0);
    cycle(0, 0, 0, 1, 0, 0, 0);
    cycle(0, 0, 0, 1, 0, 0, 0);
    // software writes, separately and colliding with commands
    cycle(0, 0, 0, 0, 1, 0, 8'h5A);
    cycle(0, 0, 0, 0, 0, 1, 8'h04);
    cycle(1, 0, 0, 0, 1, 0, 8'h80);
    cycle(0, 0, 0, 1, 0, 1, 8'h03);
    // floor region
    setSp(16'h0102);
    cycle(1, 0, 0, 0, 0, 0, 0);     // addr 0x0102 ok
    cycle(1, 0, 0, 0, 0, 0, 0);     // addr 0x0101 ok
    cycle(1, 0, 0, 0, 0, 0, 0);     // addr 0x0100 flagged
    setSp(16'h0102);
    cycle(0, 0, 1, 0, 0, 0, 0);     // 0x0102,0x0101 ok
    cycle(0, 0, 1, 0, 0, 0, 0);     // 0x0100,0x00FF flagged
    // top region
    setSp(16'h08FE);
    cycle(0, 0, 0, 1, 0, 0, 0);     // second byte 0x0900 flagged
    setSp(16'h08FF);
    cycle(0, 1, 0, 0, 0, 0, 0);     // 0x0900 flagged
    // malformed commands
    cycle(1, 1, 0, 0, 0, 0, 0);
    cycle(0, 0, 1, 1, 0, 0, 0);
    cycle(1, 0, 1, 1, 0, 0, 0);

    for (int i = 0; i < 400; i++) begin
      int r, c;
      r = $urandom_range(0, 15);
      c = $urandom_range(0, 3);
      if (r == 0)      cycle(0, 0, 0, 0, 1, 0, 8'($urandom));
      else if (r == 1) cycle(0, 0, 0, 0, 0, 1, 8'($urandom_range(0, 9)));
      else if (r == 2) cycle(1, 1, c[0], c[1], 0, 0, 0);
      else if (r == 3) cycle(c == 0, c == 1, c == 2, c == 3, 1, 0, 8'($urandom));
      else             cycle(c == 0, c == 1, c == 2, c == 3, 0, 0, 0);
    end

    // 8-bit instance: dead high byte and wrap (R9)
    sWrHi = 1; sData = 8'h12;
    @(negedge clk);
    sWrHi = 0;
    check("R9", sRdHi, 8'h00);
    check("R9", sRdLo, 8'hF0);
    sWrLo = 1; sData = 8'h01;
    @(negedge clk);
    sWrLo = 0;
    check("R9", sRdLo, 8'h01);
    sCall = 1;
    #1;
    check("R9", sAddr1, 16'h0000);
    @(negedge clk);
    sCall = 0;
    check("R9", {sRdHi, sRdLo}, 16'h00FF);
    sPush = 1;
    @(negedge clk);
    sPush = 0;
    check("R9", {sRdHi, sRdLo}, 16'h00FE);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule